// File: doc/BRIEF.md
# Counting-Semaphore Channel Control Register File

This block is the memory-mapped control and status register file of a four-channel command co-processor. Software gives each channel the address of a command descriptor and then starts work by adding to that channel's counting semaphore, rather than by setting a go bit. A channel asks for service while it is enabled and its count is non-zero. A round-robin arbiter passes the request on to one shared processing engine. The engine is outside this block, and so is descriptor fetch.

The engine reports the end of each job with a one-cycle `engDone` pulse, which carries the job's status word and two per-descriptor flags. One flag decrements the channel's semaphore. The other raises the channel's bit in a shared interrupt status word. Every status word has a write-one-to-clear alias. A single interrupt output combines the status bits that are enabled. The register interface is a single-cycle write strobe with an address, plus a read-data bus that follows the address combinationally. Reads have no side effects.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset, every register reads zero, except the capability word, which is constant. `irq` and `engStart` are low.
- R2: Channel n has a 32-bit read/write command pointer at 0x100 + 0x40*n. When channel n is granted, `engPtr` carries that pointer.
- R3: Channel n's semaphore is at 0x110 + 0x40*n and holds an 8-bit count. A write adds `regWdata[7:0]` to the count, saturating at 255. A read returns the count in bits [7:0].
- R4: The register at 0x20 holds an 8-bit channel-enable mask, with bit n for channel n. A channel requests service only when its mask bit is 1 and its count is non-zero.
- R5: When no job is outstanding and some channel requests, `engStart` is high in that cycle, with `engChan` naming the winner. The start is taken at the next rising edge. The search runs upward from the channel after the one granted last, so channel 0 goes first after reset.
- R6: After an accepted start, `engStart` stays low until the cycle after the matching `engDone`.
- R7: An `engDone` with `engDecSema` high lowers the active channel's count by one, never below zero. A semaphore write in the same cycle combines with it, giving a net change of the written amount minus one.
- R8: An `engDone` ORs `engStat` into the active channel's status word at 0x120 + 0x40*n. If `engRaiseIrq` is also high, it sets bit n of the global status word at 0x10, which has one flag per channel in bits [3:0].
- R9: A write to 0x18 clears the global status bits where the data has a 1. A write to 0x128 + 0x40*n does the same for channel n's status. A bit set by `engDone` in the same cycle stays set.
- R10: `irq` is high when some global status bit n is 1 and bit n of the read/write interrupt-enable register at 0x00 (bits [3:0]) is also 1.
- R11: The capability word at 0x40 reads 0x00050001: AES-128 at bit 0, SHA-1 at bit 16 and SHA-256 at bit 18. Writes to 0x40, to 0x10 and to the channel status addresses are ignored. The clear aliases and unmapped addresses read zero.
- R12: An `engDone` while no job is outstanding changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address for read and write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` |
| engStart | output | 1 | Start request to the engine; taken at the next rising edge |
| engChan | output | 2 | Granted channel, valid with `engStart` |
| engPtr | output | 32 | Command pointer of the granted channel, valid with `engStart` |
| engDone | input | 1 | Engine finished the outstanding job |
| engStat | input | 32 | Job status; non-zero means error |
| engDecSema | input | 1 | Descriptor asks for a semaphore decrement |
| engRaiseIrq | input | 1 | Descriptor asks for an interrupt flag |
| irq | output | 1 | Combined, enabled interrupt |

## Verification
Every register write and every `engDone` shows its effect one rising edge later:
- The read data for a written register shows the new value after that edge.
- The status words and `irq` update after that edge.
- The count changes after that edge.

`engStart` rises combinationally in the first cycle in which a channel qualifies, and it drops one edge after the start is taken. The bench drives inputs on the falling edge. A behavioural model advances on the rising edge with the same inputs. At the next falling edge the bench compares `irq`, `engStart`, the grant and the read data for the current address. Every result is therefore checked exactly one cycle after the stimulus that produced it.

// File: rtl/chan_regs_pkg.sv
package chan_regs_pkg;

  localparam int unsigned REG_W = 32;
  localparam int unsigned IDX_W = 8;

  // Global register offsets.
  localparam int unsigned A_IRQ_EN = 'h000;
  localparam int unsigned A_GSTAT  = 'h010;
  localparam int unsigned A_GCLR   = 'h018;
  localparam int unsigned A_CHEN   = 'h020;
  localparam int unsigned A_CAPS   = 'h040;

  // Per-channel window.
  localparam int unsigned CH_BASE   = 'h100;
  localparam int unsigned CH_STRIDE = 'h40;
  localparam int unsigned OFF_W     = $clog2(CH_STRIDE);
  localparam int unsigned O_PTR     = 'h00;
  localparam int unsigned O_SEMA    = 'h10;
  localparam int unsigned O_STAT    = 'h20;
  localparam int unsigned O_SCLR    = 'h28;

  localparam logic [REG_W-1:0] CAPS_VALUE = 32'h0005_0001;

  // Completion strobes from control to datapath.
  typedef struct packed {
    logic             done;
    logic             decSema;
    logic             raiseIrq;
    logic [IDX_W-1:0] chan;
    logic [REG_W-1:0] stat;
  } engStrobe_t;

endpackage

// File: rtl/chan_rr_arb.sv
module chan_rr_arb #(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [CH_W-1:0]   lastGrant,
  output logic              anyReq,
  output logic [CH_W-1:0]   grant
);

  assign anyReq = |req;

  always_comb begin
    logic found;
    int   idx;
    found = 1'b0;
    grant = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = (int'(lastGrant) + k) % NUM_CH;
      if (!found && req[idx]) begin
        grant = CH_W'(idx);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/chan_ctl_seq.sv
module chan_ctl_seq
  import chan_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0]            eligible,
  input  logic [NUM_CH-1:0][REG_W-1:0] cmdPtrs,
  input  logic                         engDone,
  input  logic [REG_W-1:0]             engStat,
  input  logic                         engDecSema,
  input  logic                         engRaiseIrq,
  output logic                         engStart,
  output logic [CH_W-1:0]              engChan,
  output logic [REG_W-1:0]             engPtr,
  output engStrobe_t                   strobe,
  output logic                         busy,
  output logic [CH_W-1:0]              actChan
);

  logic [CH_W-1:0] lastGrant;
  logic [CH_W-1:0] grant;
  logic            anyReq;

  chan_rr_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req      (eligible),
    .lastGrant(lastGrant),
    .anyReq   (anyReq),
    .grant    (grant)
  );

  assign engStart = !busy && anyReq;
  assign engChan  = grant;
  assign engPtr   = cmdPtrs[grant];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      actChan   <= '0;
      lastGrant <= CH_W'(NUM_CH - 1);
    end else if (engStart) begin
      busy      <= 1'b1;
      actChan   <= grant;
      lastGrant <= grant;
    end else if (engDone) begin
      busy      <= 1'b0;
    end
  end

  // A completion only counts while a job is outstanding.
  assign strobe.done     = engDone && busy;
  assign strobe.decSema  = engDecSema;
  assign strobe.raiseIrq = engRaiseIrq;
  assign strobe.chan     = IDX_W'(actChan);
  assign strobe.stat     = engStat;

endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank
  import chan_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int EN_W   = 8,
  parameter int SEMA_W = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWe,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [REG_W-1:0]             regWdata,
  output logic [REG_W-1:0]             regRdata,
  input  engStrobe_t                   strobe,
  output logic [NUM_CH-1:0][REG_W-1:0] cmdPtrs,
  output logic [NUM_CH-1:0]            eligible,
  output logic [NUM_CH-1:0]            intStat,
  output logic [NUM_CH-1:0]            irqEn,
  output logic                         irq
);

  logic [EN_W-1:0]                  chEnQ;
  logic [NUM_CH-1:0][SEMA_W-1:0]    semaQ;
  logic [NUM_CH-1:0][REG_W-1:0]     statQ;

  // Address decode.
  logic [ADDR_W-1:0] chRel;
  logic              isCh;
  logic [CH_W-1:0]   chSel;
  logic [OFF_W-1:0]  chOff;

  assign chRel = regAddr - ADDR_W'(CH_BASE);
  assign isCh  = (regAddr >= ADDR_W'(CH_BASE)) &&
                 (chRel < ADDR_W'(NUM_CH * CH_STRIDE));
  assign chSel = chRel[OFF_W +: CH_W];
  assign chOff = chRel[OFF_W-1:0];

  logic wrGlob;
  assign wrGlob = regWe && !isCh;

  // Global registers.
  logic [NUM_CH-1:0] gClr, gSet;
  assign gClr = (wrGlob && regAddr == ADDR_W'(A_GCLR)) ? regWdata[NUM_CH-1:0] : '0;
  assign gSet = (strobe.done && strobe.raiseIrq) ? (NUM_CH'(1) << strobe.chan) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn   <= '0;
      chEnQ   <= '0;
      intStat <= '0;
    end else begin
      if (wrGlob && regAddr == ADDR_W'(A_IRQ_EN)) irqEn <= regWdata[NUM_CH-1:0];
      if (wrGlob && regAddr == ADDR_W'(A_CHEN))   chEnQ <= regWdata[EN_W-1:0];
      intStat <= (intStat & ~gClr) | gSet;
    end
  end

  assign irq = |(intStat & irqEn);

  // Per-channel registers.
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic              hitCh;
    logic              wrPtr, wrSema, wrSclr;
    logic              doneHere;
    logic [SEMA_W-1:0] incAmt;
    logic [SEMA_W+1:0] semaSum;
    logic [REG_W-1:0]  sClr, sSet;

    assign hitCh    = regWe && isCh && (chSel == CH_W'(n));
    assign wrPtr    = hitCh && (chOff == OFF_W'(O_PTR));
    assign wrSema   = hitCh && (chOff == OFF_W'(O_SEMA));
    assign wrSclr   = hitCh && (chOff == OFF_W'(O_SCLR));
    assign doneHere = strobe.done && (strobe.chan == IDX_W'(n));

    assign incAmt  = wrSema ? regWdata[SEMA_W-1:0] : '0;
    assign semaSum = {2'b00, semaQ[n]} + {2'b00, incAmt}
                   - (SEMA_W+2)'(doneHere && strobe.decSema);

    assign sClr = wrSclr ? regWdata : '0;
    assign sSet = doneHere ? strobe.stat : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmdPtrs[n] <= '0;
        semaQ[n]   <= '0;
        statQ[n]   <= '0;
      end else begin
        if (wrPtr) cmdPtrs[n] <= regWdata;
        if (semaSum[SEMA_W+1])   semaQ[n] <= '0;
        else if (semaSum[SEMA_W]) semaQ[n] <= '1;
        else                      semaQ[n] <= semaSum[SEMA_W-1:0];
        statQ[n] <= (statQ[n] & ~sClr) | sSet;
      end
    end

    assign eligible[n] = chEnQ[n] && (semaQ[n] != '0);
  end

  // Read path.
  always_comb begin
    regRdata = '0;
    if (isCh) begin
      if (chOff == OFF_W'(O_PTR))       regRdata = cmdPtrs[chSel];
      else if (chOff == OFF_W'(O_SEMA)) regRdata = REG_W'(semaQ[chSel]);
      else if (chOff == OFF_W'(O_STAT)) regRdata = statQ[chSel];
    end else begin
      if (regAddr == ADDR_W'(A_IRQ_EN))     regRdata = REG_W'(irqEn);
      else if (regAddr == ADDR_W'(A_GSTAT)) regRdata = REG_W'(intStat);
      else if (regAddr == ADDR_W'(A_CHEN))  regRdata = REG_W'(chEnQ);
      else if (regAddr == ADDR_W'(A_CAPS))  regRdata = CAPS_VALUE;
    end
  end

endmodule

// File: rtl/chan_ctl_regs.sv
module chan_ctl_regs
  import chan_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12,
  parameter int EN_W   = 8,
  parameter int SEMA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWe,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [31:0]                regWdata,
  output logic [31:0]                regRdata,
  output logic                       engStart,
  output logic [$clog2(NUM_CH)-1:0]  engChan,
  output logic [31:0]                engPtr,
  input  logic                       engDone,
  input  logic [31:0]                engStat,
  input  logic                       engDecSema,
  input  logic                       engRaiseIrq,
  output logic                       irq
);

  localparam int CH_W = $clog2(NUM_CH);

  engStrobe_t                   strobe;
  logic [NUM_CH-1:0][REG_W-1:0] cmdPtrs;
  logic [NUM_CH-1:0]            chanElig;
  logic [NUM_CH-1:0]            intStat;
  logic [NUM_CH-1:0]            irqEn;
  logic                         ctlBusy;
  logic [CH_W-1:0]              ctlActChan;

  chan_ctl_seq #(.NUM_CH(NUM_CH)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .eligible   (chanElig),
    .cmdPtrs    (cmdPtrs),
    .engDone    (engDone),
    .engStat    (engStat),
    .engDecSema (engDecSema),
    .engRaiseIrq(engRaiseIrq),
    .engStart   (engStart),
    .engChan    (engChan),
    .engPtr     (engPtr),
    .strobe     (strobe),
    .busy       (ctlBusy),
    .actChan    (ctlActChan)
  );

  chan_reg_bank #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .EN_W(EN_W), .SEMA_W(SEMA_W)
  ) u_bank (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .strobe  (strobe),
    .cmdPtrs (cmdPtrs),
    .eligible(chanElig),
    .intStat (intStat),
    .irqEn   (irqEn),
    .irq     (irq)
  );

endmodule

// File: rtl/chan_ctl_regs_chk.sv
module chan_ctl_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      regWe,
  input logic [ADDR_W-1:0]         regAddr,
  input logic [31:0]               regWdata,
  input logic                      engStart,
  input logic [$clog2(NUM_CH)-1:0] engChan,
  input logic                      engDone,
  input logic                      engRaiseIrq,
  input logic                      busy,
  input logic [$clog2(NUM_CH)-1:0] actChan,
  input logic [NUM_CH-1:0]         eligible,
  input logic [NUM_CH-1:0]         intStat
);

  // R6: a taken start blocks the next one.
  a_r6_single_job: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R6: nothing starts while a job is outstanding.
  a_r6_busy_no_start: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !engStart);

  // R4: the granted channel is enabled and holds a non-zero count.
  a_r4_start_eligible: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> eligible[engChan]);

  // R8: a flagged completion sets the active channel's flag.
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && busy && engRaiseIrq) |=> intStat[$past(actChan)]);

  // R9: a clear with no concurrent set leaves the written bits low.
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'('h18) && !(engDone && busy && engRaiseIrq))
      |=> ((intStat & $past(regWdata[NUM_CH-1:0])) == '0));

  // R12: a completion with no outstanding job leaves the flags alone.
  a_r12_idle_done: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && !busy && !regWe) |=> $stable(intStat));

endmodule

bind chan_ctl_regs chan_ctl_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .engStart   (engStart),
  .engChan    (engChan),
  .engDone    (engDone),
  .engRaiseIrq(engRaiseIrq),
  .busy       (ctlBusy),
  .actChan    (ctlActChan),
  .eligible   (chanElig),
  .intStat    (intStat)
);

// File: tb/test_chan_ctl_regs.sv
module test_chan_ctl_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        engStart;
  logic [1:0]  engChan;
  logic [31:0] engPtr;
  logic        engDone = 1'b0;
  logic [31:0] engStat = '0;
  logic        engDecSema = 1'b0;
  logic        engRaiseIrq = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_ctl_regs i_chan_ctl_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engStart(engStart),
    .engChan(engChan), .engPtr(engPtr), .engDone(engDone),
    .engStat(engStat), .engDecSema(engDecSema),
    .engRaiseIrq(engRaiseIrq), .irq(irq)
  );

  // Behavioural reference model.
  logic [31:0] mPtr [NCH];
  logic [31:0] mStat[NCH];
  int          mSema[NCH];
  logic [7:0]  mEn;
  logic [3:0]  mIen, mGst;
  bit          mBusy;
  int          mAct, mLast;

  function automatic int mGrant();
    for (int k = 1; k <= NCH; k++) begin
      int c = (mLast + k) % NCH;
      if (mEn[c] && mSema[c] > 0) return c;
    end
    return -1;
  endfunction

  function automatic logic [31:0] mRead(logic [11:0] a);
    int ai = int'(a);
    if (ai == 'h00) return {28'd0, mIen};
    if (ai == 'h10) return {28'd0, mGst};
    if (ai == 'h20) return {24'd0, mEn};
    if (ai == 'h40) return 32'h0005_0001;
    if (ai >= 'h100 && ai < 'h200) begin
      int c = (ai - 'h100) / 'h40;
      int off = ai % 'h40;
      if (off == 'h00) return mPtr[c];
      if (off == 'h10) return 32'(mSema[c]);
      if (off == 'h20) return mStat[c];
    end
    return 32'd0;
  endfunction

  function automatic string rtag(logic [11:0] a);
    int ai = int'(a);
    if (ai == 'h00) return "R10";
    if (ai == 'h10 || ai == 'h18) return "R8";
    if (ai == 'h20) return "R4";
    if (ai >= 'h100 && ai < 'h200) begin
      int off = ai % 'h40;
      if (off == 'h00) return "R2";
      if (off == 'h10) return "R3";
      if (off == 'h20) return "R8";
    end
    return "R11";
  endfunction

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      mPtr[c] = '0; mStat[c] = '0; mSema[c] = 0;
    end
    mEn = '0; mIen = '0; mGst = '0; mBusy = 0; mAct = 0; mLast = NCH - 1;
  endtask

  task automatic modelStep();
    int g = mGrant();
    bit st = !mBusy && (g >= 0);
    bit dn = engDone && mBusy;
    int ai = int'(regAddr);
    logic [3:0] gclr = '0;
    logic [3:0] gset = '0;
    if (regWe && ai == 'h18) gclr = regWdata[3:0];
    if (dn && engRaiseIrq) gset[mAct] = 1'b1;
    mGst = (mGst & ~gclr) | gset;
    for (int c = 0; c < NCH; c++) begin
      int inc = 0;
      int dec = 0;
      int v;
      logic [31:0] clr = '0;
      if (regWe && ai >= 'h100 + c*'h40 && ai < 'h140 + c*'h40) begin
        int off = ai % 'h40;
        if (off == 'h00) mPtr[c] = regWdata;
        if (off == 'h10) inc = int'(regWdata[7:0]);
        if (off == 'h28) clr = regWdata;
      end
      if (dn && engDecSema && mAct == c) dec = 1;
      v = mSema[c] + inc - dec;
      mSema[c] = (v < 0) ? 0 : ((v > 255) ? 255 : v);
      mStat[c] = (mStat[c] & ~clr) | ((dn && mAct == c) ? engStat : 32'd0);
    end
    if (regWe && ai == 'h00) mIen = regWdata[3:0];
    if (regWe && ai == 'h20) mEn = regWdata[7:0];
    if (st) begin
      mBusy = 1; mAct = g; mLast = g;
    end else if (dn) begin
      mBusy = 0;
    end
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int g = mGrant();
    bit es = !mBusy && (g >= 0);
    logic [31:0] er = mRead(regAddr);
    logic        ei = |(mGst & mIen);
    chk(irq == ei, "R10", 32'(irq), 32'(ei));
    chk(engStart == es, "R5", 32'(engStart), 32'(es));
    if (es && engStart) begin
      chk(int'(engChan) == g, "R5", 32'(engChan), 32'(g));
      chk(engPtr == mPtr[g], "R2", engPtr, mPtr[g]);
    end
    chk(regRdata == er, rtag(regAddr), regRdata, er);
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rstN) modelReset(); else modelStep();
    @(negedge clk);
    if (rstN) compareAll();
  endtask

  task automatic wr(int a, logic [31:0] d);
    regWe = 1'b1; regAddr = 12'(a); regWdata = d;
    tick();
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rdLit(int a, logic [31:0] exp, string tag);
    regAddr = 12'(a);
    tick();
    chk(regRdata == exp, tag, regRdata, exp);
  endtask

  task automatic doneOnly(logic [31:0] st, bit dec, bit fl);
    engDone = 1'b1; engStat = st; engDecSema = dec; engRaiseIrq = fl;
    tick();
    engDone = 1'b0; engStat = '0; engDecSema = 1'b0; engRaiseIrq = 1'b0;
  endtask

  task automatic runJob(logic [31:0] st, bit dec, bit fl, int hold);
    int w = 0;
    while (!engStart && w < 50) begin tick(); w++; end
    chk(engStart == 1'b1, "R5", 32'(engStart), 32'd1);
    tick();
    for (int h = 0; h < hold; h++) begin
      chk(engStart == 1'b0, "R6", 32'(engStart), 32'd0);
      tick();
    end
    doneOnly(st, dec, fl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1: reset state
    chk(irq == 1'b0, "R1", 32'(irq), 32'd0);
    chk(engStart == 1'b0, "R1", 32'(engStart), 32'd0);
    rdLit('h10, 32'd0, "R1");
    rdLit('h110, 32'd0, "R1");
    rdLit('h120, 32'd0, "R1");
    rdLit('h40, 32'h0005_0001, "R11");

    // R2: command pointers
    for (int n = 0; n < NCH; n++) wr('h100 + n*'h40, 32'hA000_0000 + n*'h100);
    rdLit('h140, 32'hA000_0100, "R2");

    // R11: read-only words ignore writes
    wr('h40, 32'd0);
    rdLit('h40, 32'h0005_0001, "R11");
    wr('h10, 32'hF);
    rdLit('h10, 32'd0, "R11");
    wr('h120, 32'hFFFF);
    rdLit('h120, 32'd0, "R11");
    rdLit('h18, 32'd0, "R11");

    // R3: saturation on channel 3 (kept disabled)
    wr('h1D0, 32'd250);
    wr('h1D0, 32'd10);
    rdLit('h1D0, 32'd255, "R3");

    // R4: counts without enable do not start
    wr('h110, 32'd2);
    wr('h150, 32'd1);
    wr('h190, 32'd1);
    tick();
    chk(engStart == 1'b0, "R4", 32'(engStart), 32'd0);

    // R5: round robin from channel 0
    wr('h00, 32'h5);
    wr('h20, 32'h07);
    chk(engChan == 2'd0, "R5", 32'(engChan), 32'd0);
    runJob(32'd0, 1'b1, 1'b1, 3);
    chk(engChan == 2'd1, "R5", 32'(engChan), 32'd1);
    runJob(32'd0, 1'b1, 1'b1, 2);
    chk(engChan == 2'd2, "R5", 32'(engChan), 32'd2);
    runJob(32'd0, 1'b1, 1'b1, 1);
    chk(engChan == 2'd0, "R5", 32'(engChan), 32'd0);
    chk(engPtr == 32'hA000_0000, "R2", engPtr, 32'hA000_0000);
    chk(irq == 1'b1, "R10", 32'(irq), 32'd1);

    // R8: error status, no decrement -> channel 0 runs again
    runJob(32'h2, 1'b0, 1'b0, 1);
    rdLit('h120, 32'h2, "R8");
    wr('h128, 32'hFFFF_FFFF);
    rdLit('h120, 32'd0, "R9");

    // R9 / R10: clear global flags
    wr('h18, 32'h1);
    rdLit('h10, 32'h6, "R9");
    chk(irq == 1'b1, "R10", 32'(irq), 32'd1);
    wr('h18, 32'h4);
    chk(irq == 1'b0, "R10", 32'(irq), 32'd0);

    // R7: increment and decrement in one cycle (channel 0 is busy)
    regWe = 1'b1; regAddr = 12'h110; regWdata = 32'd1;
    engDone = 1'b1; engDecSema = 1'b1; engRaiseIrq = 1'b1;
    tick();
    regWe = 1'b0; regWdata = '0;
    engDone = 1'b0; engDecSema = 1'b0; engRaiseIrq = 1'b0;
    rdLit('h110, 32'd1, "R7");

    // R9: set wins over clear in the same cycle
    regWe = 1'b1; regAddr = 12'h018; regWdata = 32'h1;
    engDone = 1'b1; engDecSema = 1'b1; engRaiseIrq = 1'b1;
    tick();
    regWe = 1'b0; regWdata = '0;
    engDone = 1'b0; engDecSema = 1'b0; engRaiseIrq = 1'b0;
    rdLit('h10, 32'h3, "R9");
    rdLit('h110, 32'd0, "R7");

    // R12: completion while idle
    wr('h18, 32'hF);
    chk(engStart == 1'b0, "R12", 32'(engStart), 32'd0);
    doneOnly(32'h55, 1'b1, 1'b1);
    rdLit('h10, 32'd0, "R12");
    rdLit('h120, 32'd0, "R12");
    chk(engStart == 1'b0, "R12", 32'(engStart), 32'd0);

    // R3 / R7: multi-step add and decrement on channel 2
    wr('h190, 32'd3);
    rdLit('h190, 32'd3, "R3");
    doneOnly(32'd0, 1'b1, 1'b0);
    rdLit('h190, 32'd2, "R7");

    // R4: disabling stops restarts
    wr('h20, 32'h00);
    doneOnly(32'd0, 1'b1, 1'b0);
    chk(engStart == 1'b0, "R4", 32'(engStart), 32'd0);
    rdLit('h190, 32'd1, "R4");
    wr('h20, 32'h04);
    chk(engChan == 2'd2, "R5", 32'(engChan), 32'd2);
    chk(engPtr == 32'hA000_0200, "R2", engPtr, 32'hA000_0200);
    tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule